// File: doc/BRIEF.md
# Three-Source Shift-Mask Logic Unit

This unit executes one class of three-operand integer instructions. Each operation either shifts one operand by an amount taken from another or ANDs the two together. It then combines that intermediate value with a third operand, using a bitwise AND (masking) or a bitwise OR (merging). The whole operation completes in a single issue. Operand values arrive already resolved from the register file, one per source. Each source has its own invert flag, and a single precision flag selects between full 32-bit and half 16-bit operation.

A request is presented with an input valid strobe. The result and its matching valid appear registered on the next clock edge. Opcodes outside the supported set return zero and raise an illegal-opcode flag alongside the valid.

Top module: `tri_shmask_unit`

## Requirements
- R1: After reset deasserts and before any request, `valid_o` is 0, `result_o` is 0 and `illegal_o` is 0.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high, and low otherwise. `result_o` and `illegal_o` hold their values while `valid_o` is low.
- R3: Opcode 4'b1000 yields (b >> s) & c, where a is the src1 operand, b the src2 operand, c the src3 operand, and s the shift amount taken from a.
- R4: Opcode 4'b1001 yields (b << s) & c.
- R5: Opcode 4'b1010 yields (b >> s) | c, and opcode 4'b1011 yields (b << s) | c.
- R6: Opcode 4'b1100 yields (b & a) | c. No shift takes place.
- R7: Shifts are logical and shift in zeros. In full mode (`full_i`=1) s is a[4:0]. In half mode s is a[3:0], and the higher bits of src1 are ignored.
- R8: Each set invert flag (`inv_i[0]` for src1, `inv_i[1]` for src2, `inv_i[2]` for src3) replaces that source by its bitwise NOT before the operation. This also applies to src1 when it is used as a shift amount.
- R9: In half mode only bits [15:0] of each source are used, and bits [31:16] of the result are 0.
- R10: Opcodes 4'b0000 to 4'b0111 and 4'b1101 to 4'b1111 give a result of 0 with `illegal_o`=1. Legal opcodes give `illegal_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Opcode |
| src1_i | input | 32 | Shift amount, or AND operand for opcode 1100 |
| src2_i | input | 32 | Value that is shifted or ANDed |
| src3_i | input | 32 | Mask or merge operand |
| inv_i | input | 3 | Per-source invert flags, bit n belongs to source n+1 |
| full_i | input | 1 | 1 selects 32-bit mode, 0 selects 16-bit mode |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Opcode was not in the supported set |

## Verification
A wrong internal state shows up at the ports on the single output edge that follows a request, because every path passes through exactly one register. The likely faults each leave a different signature in `result_o`. A stuck or wrong shift amount width moves bits to the wrong positions. A missing half-mode clear leaves junk in the upper 16 bits. A misrouted combine selects AND where OR was due, or the reverse. A decode slip shows as a nonzero result or a wrong `illegal_o`. A valid pipeline that is off by one shows as `valid_o` high or low in the wrong cycle.

// File: rtl/tri_shmask_pkg.sv
package tri_shmask_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHR_AND = 4'b1000,
    OP_SHL_AND = 4'b1001,
    OP_SHR_OR  = 4'b1010,
    OP_SHL_OR  = 4'b1011,
    OP_AND_OR  = 4'b1100
  } tri_op_e;

  typedef enum logic [1:0] {
    PRE_SHR,
    PRE_SHL,
    PRE_AND
  } pre_sel_e;

  typedef struct packed {
    logic     legal;
    pre_sel_e pre;
    logic     merge;   // 1: OR with src3, 0: AND with src3
  } tri_ctrl_t;
endpackage

// File: rtl/tri_shmask_decode.sv
module tri_shmask_decode
  import tri_shmask_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output tri_ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '{legal: 1'b0, pre: PRE_AND, merge: 1'b0};
    case (op_i)
      OP_SHR_AND: ctrl_o = '{legal: 1'b1, pre: PRE_SHR, merge: 1'b0};
      OP_SHL_AND: ctrl_o = '{legal: 1'b1, pre: PRE_SHL, merge: 1'b0};
      OP_SHR_OR:  ctrl_o = '{legal: 1'b1, pre: PRE_SHR, merge: 1'b1};
      OP_SHL_OR:  ctrl_o = '{legal: 1'b1, pre: PRE_SHL, merge: 1'b1};
      OP_AND_OR:  ctrl_o = '{legal: 1'b1, pre: PRE_AND, merge: 1'b1};
      default:    ctrl_o = '{legal: 1'b0, pre: PRE_AND, merge: 1'b0};
    endcase
  end
endmodule

// File: rtl/tri_shmask_operand.sv
module tri_shmask_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              inv_i,
  input  logic              full_i,
  output logic [DATA_W-1:0] opnd_o
);
  logic [DATA_W-1:0] flipped;
  logic [DATA_W-1:0] keep_mask;

  assign flipped   = inv_i ? ~raw_i : raw_i;
  assign keep_mask = full_i ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign opnd_o    = flipped & keep_mask;
endmodule

// File: rtl/tri_shmask_datapath.sv
module tri_shmask_datapath
  import tri_shmask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              full_i,
  input  tri_ctrl_t         ctrl_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] shr, shl, pre, comb;

  // half mode drops the top shift-amount bit
  assign shamt = full_i ? a_i[SH_W-1:0] : {1'b0, a_i[SH_W-2:0]};
  assign shr   = b_i >> shamt;
  assign shl   = b_i << shamt;

  always_comb begin
    case (ctrl_i.pre)
      PRE_SHR: pre = shr;
      PRE_SHL: pre = shl;
      default: pre = b_i & a_i;
    endcase
    comb = ctrl_i.merge ? (pre | c_i) : (pre & c_i);
    if (!full_i) comb = comb & HALF_MASK;
    res_o = ctrl_i.legal ? comb : '0;
  end
endmodule

// File: rtl/tri_shmask_unit.sv
module tri_shmask_unit
  import tri_shmask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] src3_i,
  input  logic [N_SRC-1:0]  inv_i,
  input  logic              full_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] raw   [N_SRC];
  logic [DATA_W-1:0] opnd  [N_SRC];
  tri_ctrl_t         ctrl;
  logic [DATA_W-1:0] res_d;

  assign raw[0] = src1_i;
  assign raw[1] = src2_i;
  assign raw[2] = src3_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
    tri_shmask_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_opnd (
      .raw_i  (raw[g]),
      .inv_i  (inv_i[g]),
      .full_i (full_i),
      .opnd_o (opnd[g])
    );
  end

  tri_shmask_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  tri_shmask_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_dp (
    .a_i    (opnd[0]),
    .b_i    (opnd[1]),
    .c_i    (opnd[2]),
    .full_i (full_i),
    .ctrl_i (ctrl),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        illegal_o <= ~ctrl.legal;
      end
    end
  end
endmodule

// File: rtl/tri_shmask_chk.sv
module tri_shmask_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              full_i,
  input logic [3:0]        op_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(illegal_o)));
  // R9
  half_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !full_i) |=> (result_o[DATA_W-1:DATA_W/2] == '0));
  // R10
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (result_o == '0));
  // R10
  illegal_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i[3] == 1'b0 || op_i[3:2] == 2'b11 && op_i[1:0] != 2'b00))
      |=> illegal_o);
endmodule

bind tri_shmask_unit tri_shmask_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .full_i    (full_i),
  .op_i      (op_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/tri_shmask_unit_test.sv
module tri_shmask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] s1 = '0, s2 = '0, s3 = '0;
  logic [2:0]  inv = '0;
  logic        full = 1'b1;
  logic        valid_o, illegal_o;
  logic [31:0] result_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tri_shmask_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .src1_i(s1), .src2_i(s2), .src3_i(s3), .inv_i(inv), .full_i(full),
    .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a0,
                                        input logic [31:0] b0, input logic [31:0] c0,
                                        input logic [2:0] iv, input logic fl);
    logic [31:0] a, b, c, m, r;
    int sh;
    m = fl ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    a = (iv[0] ? ~a0 : a0) & m;
    b = (iv[1] ? ~b0 : b0) & m;
    c = (iv[2] ? ~c0 : c0) & m;
    sh = fl ? int'(a[4:0]) : int'(a[3:0]);
    case (op)
      4'b1000: r = (b >> sh) & c;
      4'b1001: r = (b << sh) & c;
      4'b1010: r = (b >> sh) | c;
      4'b1011: r = (b << sh) | c;
      4'b1100: r = (b & a) | c;
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, r & m};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c,
                       input logic [2:0] iv, input logic fl);
    logic [32:0] e;
    e = model(op, a, b, c, iv, fl);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; s1 = a; s2 = b; s3 = c; inv = iv; full = fl;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, {31'b0, valid_o}, 32'd1);
    check(req, result_o, e[31:0]);
    check(req, {31'b0, illegal_o}, {31'b0, e[32]});
  endtask

  task automatic t_reset();
    check("R1", {31'b0, valid_o}, 0);
    check("R1", result_o, 0);
    check("R1", {31'b0, illegal_o}, 0);
  endtask

  task automatic t_ops();
    issue("R3", 4'b1000, 32'd4, 32'hF0F0_1234, 32'h0FFF_00FF, 3'b000, 1'b1);
    issue("R4", 4'b1001, 32'd8, 32'h00AB_CDEF, 32'hFF00_FF00, 3'b000, 1'b1);
    issue("R5", 4'b1010, 32'd31, 32'h8000_0000, 32'h0000_0100, 3'b000, 1'b1);
    issue("R5", 4'b1011, 32'd16, 32'h0000_1234, 32'h0000_0F0F, 3'b000, 1'b1);
    issue("R6", 4'b1100, 32'h0000_0004, 32'h0000_FFFF, 32'h0300_0000, 3'b000, 1'b1);
  endtask

  task automatic t_shift_width();
    // upper src1 bits ignored
    issue("R7", 4'b1000, 32'hFFFF_FFE3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 1'b1);
    issue("R7", 4'b1001, 32'h0000_0013, 32'h0000_00FF, 32'h0000_FFFF, 3'b000, 1'b0);
    issue("R7", 4'b1000, 32'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'b000, 1'b1);
  endtask

  task automatic t_invert();
    issue("R8", 4'b1000, 32'hFFFF_FFFE, 32'h0000_00F0, 32'hFFFF_FFFF, 3'b001, 1'b1);
    issue("R8", 4'b1010, 32'd0, 32'h0000_0000, 32'hFFFF_0000, 3'b110, 1'b1);
    issue("R8", 4'b1100, 32'h0000_00FF, 32'h1234_5678, 32'h0, 3'b011, 1'b1);
  endtask

  task automatic t_half();
    issue("R9", 4'b1011, 32'd4, 32'hABCD_F123, 32'hFFFF_0000, 3'b000, 1'b0);
    issue("R9", 4'b1010, 32'd0, 32'h0, 32'h0, 3'b100, 1'b0);
  endtask

  task automatic t_illegal();
    issue("R10", 4'b0000, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 1'b1);
    issue("R10", 4'b0111, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111, 1'b1);
    issue("R10", 4'b1101, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 1'b1);
    issue("R10", 4'b1111, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 1'b0);
    issue("R10", 4'b1100, 32'd1, 32'd1, 32'd0, 3'b000, 1'b1);
  endtask

  task automatic t_hold();
    logic [31:0] last;
    issue("R2", 4'b1011, 32'd1, 32'd3, 32'd0, 3'b000, 1'b1);
    last = result_o;
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'b1100; s1 = '1; s2 = '1; s3 = '1;
    @(negedge clk);
    check("R2", {31'b0, valid_o}, 0);
    check("R2", result_o, last);
    check("R2", {31'b0, illegal_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ops();
    t_shift_width();
    t_invert();
    t_half();
    t_illegal();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule